// File: doc/BRIEF.md
# Deferred Conversion Start Sequencer

This block decides when a successive-approximation converter's track/hold goes into hold and how long the conversion that follows lasts. A convert-start request arrives asynchronously. It is brought onto the master clock by a two-flop synchroniser, and only its low-to-high transition counts. A control-register update fires a settling pulse. The pulse length is a programmable number of master-clock cycles, and it gives external filtering time to settle.

If the settling pulse has run out when the start edge is seen, hold and conversion begin at once. If the pulse is still running, the request is remembered as a single pending request. Hold and conversion then begin on the first cycle after the pulse ends. A conversion lasts a fixed number of master-clock cycles. It ends with a one-cycle done strobe, and after that the track/hold returns to track.

The controller has three states:
- WAIT_EDGE: idle, tracking.
- HOLD_PENDING: an edge was accepted during the settling pulse.
- CONVERTING: in hold.

It has four transitions:
- WAIT_EDGE to CONVERTING on an edge while the pulse is idle.
- WAIT_EDGE to HOLD_PENDING on an edge while the pulse is active.
- HOLD_PENDING to CONVERTING when the pulse expires.
- CONVERTING to WAIT_EDGE on the last conversion cycle.

Top module: `conv_start_seq`

## Requirements
- R1: A conversion is requested only by a low-to-high transition of `conv_start_in`. Holding the input high, or holding it low, starts nothing further.
- R2: If the settling pulse is inactive when the synchronised edge reaches the controller, `hold` rises two clock edges after the first edge that samples the input high.
- R3: If the settling pulse is active when the edge reaches the controller, the request waits. `hold` rises on the clock edge after the settling counter reaches zero.
- R4: `hold` stays high for exactly CONV_CYCLES master-clock cycles. The default of 14 keeps the conversion within 5.9 µs at a 2.5 MHz master clock.
- R5: `busy` is high from the edge at which a request is accepted until the last conversion cycle, including any pending wait. `hold` implies `busy`.
- R6: `done` is high for exactly one cycle, on the last cycle of `hold`. After it, `hold` and `busy` are low.
- R7: Start edges that arrive while `busy` is high are ignored. At most one request is pending.
- R8: When `settle_trig` is sampled high, the settling counter loads `settle_len`. A trigger during a running pulse reloads the counter. A length of zero gives no pulse.
- R9: After reset, `hold`, `busy` and `done` are low and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_in | input | 1 | Asynchronous convert-start request, rising edge active |
| settle_trig | input | 1 | One-cycle pulse from a control-register update that starts the settling pulse |
| settle_len | input | SETTLE_W | Settling pulse length in master-clock cycles |
| hold | output | 1 | High: track/hold in hold (converting) |
| busy | output | 1 | Request accepted and not yet finished |
| done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
Take the edge at which the trigger is sampled as edge 0, and the edge at which the start input is first sampled high as edge d. Results are then due as follows:
- `busy` is due after edge d+2.
- `hold` is due after edge max(d+2, L+1), where L is the settling length, or the length reloaded at the last retrigger counted from that retrigger.
- `done` is due CONV_CYCLES-1 edges after `hold` rises.

The bench drives inputs on falling edges. It samples one time unit after every rising edge, and compares each output against these windows on every cycle of every case. It sweeps L from 0 to 8 against offsets d from 0 to 4, then adds retrigger, second-edge and held-level cases.

// File: rtl/conv_start_seq_pkg.sv
package conv_start_seq_pkg;
    typedef enum logic [1:0] {
        WAIT_EDGE    = 2'd0,
        HOLD_PENDING = 2'd1,
        CONVERTING   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/start_edge_sync.sv
module start_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [SETTLE_W-1:0] len,
    output logic                active
);
    logic [SETTLE_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (trig)
            remain_q <= len;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign active = (remain_q != '0);
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
    import conv_start_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_rise,
    input  logic settle_active,
    output logic hold,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_LOAD = CW'(CONV_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] left_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_EDGE: begin
                if (req_rise)
                    state_d = settle_active ? HOLD_PENDING : CONVERTING;
            end
            HOLD_PENDING: begin
                if (!settle_active)
                    state_d = CONVERTING;
            end
            CONVERTING: begin
                if (left_q == '0)
                    state_d = WAIT_EDGE;
            end
            default: state_d = WAIT_EDGE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WAIT_EDGE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != CONVERTING && state_d == CONVERTING)
                left_q <= LAST_LOAD;
            else if (state_q == CONVERTING && left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        hold = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            WAIT_EDGE: ;
            HOLD_PENDING: busy = 1'b1;
            CONVERTING: begin
                hold = 1'b1;
                busy = 1'b1;
                done = (left_q == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
    parameter int CONV_CYCLES = 14,
    parameter int SETTLE_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_in,
    input  logic                settle_trig,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                hold,
    output logic                busy,
    output logic                done
);
    logic start_rise;
    logic settle_act;

    start_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_start_in),
        .rise     (start_rise)
    );

    settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (settle_trig),
        .len    (settle_len),
        .active (settle_act)
    );

    conv_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_rise      (start_rise),
        .settle_active (settle_act),
        .hold          (hold),
        .busy          (busy),
        .done          (done)
    );
endmodule

// File: rtl/conv_start_seq_chk.sv
module conv_start_seq_chk #(
    parameter int CONV_CYCLES = 14
) (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic busy,
    input logic done,
    input logic settle_active
);
    logic [15:0] hold_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_run <= '0;
        else if (hold)
            hold_run <= hold_run + 1'b1;
        else
            hold_run <= '0;
    end

    p_hold_implies_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> busy);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!hold && !busy));

    p_done_on_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hold);

    p_hold_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !$past(settle_active));

    p_conv_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hold_run == 16'(CONV_CYCLES - 1)));

    p_hold_ends_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(done));
endmodule

bind conv_start_seq conv_start_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold          (hold),
    .busy          (busy),
    .done          (done),
    .settle_active (settle_act)
);

// File: tb/conv_start_seq_tb_top.sv
module conv_start_seq_tb_top;
    localparam int CONV = 14;
    localparam int SW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_in = 1'b0;
    logic          trig = 1'b0;
    logic [SW-1:0] len = '0;
    logic          hold, busy, done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    conv_start_seq #(.CONV_CYCLES(CONV), .SETTLE_W(SW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_start_in (start_in),
        .settle_trig   (trig),
        .settle_len    (len),
        .hold          (hold),
        .busy          (busy),
        .done          (done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
        end
    endtask

    // L: settle length, d: edge index at which start is first sampled high,
    // r: retrigger edge (-1 none), g: start of a 3-cycle low glitch (-1 none)
    task automatic run_case(input int L, input int d, input int r, input int g);
        int endp, H, D, last;
        string hreq, breq;
        endp = (r >= 0 && r < L) ? r + L : L;
        D    = d + 2;
        H    = (D > endp + 1) ? D : endp + 1;
        last = H + CONV + 1;
        hreq = (r >= 0) ? "R8" : ((H > D) ? "R3" : "R2");
        breq = (g >= 0) ? "R7" : "R5";
        for (int n = 0; n <= last; n++) begin
            @(negedge clk);
            trig     = (n == 0) || (n == r);
            len      = SW'(L);
            start_in = (n >= d) && !(g >= 0 && n >= g && n < g + 3);
            @(posedge clk);
            #1;
            chk((n >= H + CONV - 1) ? "R4" : hreq, "hold", hold,
                (n >= H && n < H + CONV));
            chk(breq, "busy", busy, (n >= D && n < H + CONV));
            chk("R6", "done", done, (n == H + CONV - 1));
        end
        @(negedge clk);
        trig = 1'b0;
        start_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "hold", hold, 1'b0);
        chk("R9", "busy", busy, 1'b0);
        chk("R9", "done", done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: high level while idle and never toggled after reset: no conversion
        // (a low-to-high at the input is still an edge, so first check low level)
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R1", "busy", busy, 1'b0);
        end

        // R2/R3/R8 sweep over settle length and start offset
        for (int L = 0; L <= 8; L++)
            for (int d = 0; d <= 4; d++)
                run_case(L, d, -1, -1);

        // R8: retrigger during pulse reloads the count
        run_case(4, 0, 2, -1);
        run_case(6, 1, 3, -1);
        // R7: second edge during conversion, and during a pending wait
        run_case(0, 0, -1, 5);
        run_case(12, 0, -1, 3);

        // R1: hold the start input high for a long time after one conversion
        @(negedge clk);
        start_in = 1'b1;
        repeat (3 + CONV) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            chk("R1", "busy", busy, 1'b0);
            chk("R1", "hold", hold, 1'b0);
        end
        @(negedge clk);
        start_in = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule